// File: doc/BRIEF.md
# SDRAM Bank Command Legality Tracker

This block sits beside an SDRAM command scheduler and decides, cycle by cycle, whether the command the scheduler presents may go to the memory now. It keeps an open/closed status for each bank. It also runs per-bank counters for the precharge recovery time, for the minimum row-active time, and for the delay before a self-closing access starts its internal precharge. A single shared counter marks the burst window of an access that carries auto-precharge.

The scheduler presents a command with `cmd_valid`. `cmd_ready` tells it whether that command is legal this cycle. `cmd_ready` depends only on the presented command fields and on the tracker state, and never on `cmd_valid`. A command takes effect only in a cycle where both `cmd_valid` and `cmd_ready` are high. When `cmd_ready` is low, the scheduler may hold the command or replace it with another one, and the tracker changes nothing. All timing values are module parameters given in clock cycles.

Top module: `sdr_bank_guard`

## Requirements
- R1: Command codes on `cmd_code` are 0 no-op, 1 activate, 2 read, 3 write and 4 precharge. A no-op is always ready, and codes 5 to 7 are never ready.
- R2: A command changes state only when `cmd_valid` and `cmd_ready` are both high. With `cmd_valid` low, no bank changes status.
- R3: An activate is ready only if the addressed bank is closed and at least TRP cycles have passed since that bank began precharging. The bank shows open from the cycle after acceptance.
- R4: A read or write is ready only if the addressed bank is open and not waiting on an auto-precharge.
- R5: A read with `cmd_a10` high closes its bank automatically. The internal precharge starts BL cycles after the command, which is CL-1 cycles before the last read data beat. The bank shows closed from the next cycle.
- R6: A write with `cmd_a10` high starts its internal precharge TWR cycles after its last data beat, which is BL-1+TWR cycles after the command. The bank may be activated again TWR+TRP cycles after that last beat.
- R7: For the BL-1 cycles after an accepted read or write with auto-precharge, every read, write and precharge is not ready. Activates to other banks stay legal.
- R8: When FULL_PAGE is set, a read or write with `cmd_a10` high is never ready. The same command with `cmd_a10` low is ready under R4.
- R9: A precharge with `cmd_a10` low closes the bank on `cmd_bank`. With `cmd_a10` high it closes every bank. A precharge is not ready while any bank it targets waits on an auto-precharge.
- R10: A precharge to a bank that is already closed is ready, has no effect, and does not restart that bank's recovery time.
- R11: An automatic precharge never starts earlier than TRAS cycles after its bank's activate. If it falls due earlier, its start waits until TRAS is met.
- R12: Reset (active-low `rst_n`, asynchronous) closes all banks and clears all timers, so every activate is ready right after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | A command is presented |
| cmd_code | input | 3 | Command code (see R1) |
| cmd_bank | input | BANK_W | Addressed bank |
| cmd_a10 | input | 1 | Auto-precharge on read/write; all-bank select on precharge |
| cmd_ready | output | 1 | Presented command is legal this cycle |
| bank_open | output | 2**BANK_W | One bit per bank, 1 = open |

## Verification
The bench builds the main instance with BL=4, CL=2, TRP=2, TRAS=6, TWR=2 and four banks. These values make the tRAS hold-off of a read with auto-precharge visible, since the read is issued one cycle after its activate. They also keep the write-side reopen point (last beat plus TWR+TRP) within a few cycles. A second instance with FULL_PAGE=1 exists only to reach the rule that forbids auto-precharge with full-page bursts.

// File: rtl/sdr_guard_pkg.sv
package sdr_guard_pkg;
  typedef enum logic [2:0] {
    CMD_NOP = 3'd0,
    CMD_ACT = 3'd1,
    CMD_RD  = 3'd2,
    CMD_WR  = 3'd3,
    CMD_PRE = 3'd4
  } cmd_e;
endpackage

// File: rtl/sdr_bank_timer.sv
// Per-bank status and counters: recovery after precharge, row-active
// minimum, and pending automatic precharge.
module sdr_bank_timer #(
  parameter int CW   = 5,
  parameter int TRP  = 2,
  parameter int TRAS = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          act_i,
  input  logic          pre_i,
  input  logic          ap_i,
  input  logic [CW-1:0] ap_delay_i,
  output logic          open_o,
  output logic          pend_o,
  output logic          rp_done_o
);
  localparam logic [CW-1:0] RP_LD  = CW'(TRP - 1);
  localparam logic [CW-1:0] RAS_LD = CW'(TRAS - 1);

  logic          open_q, pend_q;
  logic [CW-1:0] rp_q, ras_q, ap_q;
  logic          ap_fire;

  // Automatic precharge starts only once both its delay and tRAS are spent.
  assign ap_fire = pend_q && (ap_q == '0) && (ras_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      pend_q <= 1'b0;
      rp_q   <= '0;
      ras_q  <= '0;
      ap_q   <= '0;
    end else begin
      if (rp_q  != '0) rp_q  <= rp_q  - 1'b1;
      if (ras_q != '0) ras_q <= ras_q - 1'b1;
      if (ap_q  != '0) ap_q  <= ap_q  - 1'b1;
      if (act_i) begin
        open_q <= 1'b1;
        ras_q  <= RAS_LD;
      end
      if (ap_i) begin
        pend_q <= 1'b1;
        ap_q   <= ap_delay_i - 1'b1;
      end
      if ((pre_i && open_q) || ap_fire) begin
        open_q <= 1'b0;
        pend_q <= 1'b0;
        rp_q   <= RP_LD;
      end
    end
  end

  assign open_o    = open_q;
  assign pend_o    = pend_q;
  assign rp_done_o = (rp_q == '0);
endmodule

// File: rtl/sdr_burst_hold.sv
// Shared window during which a self-closing burst may not be interrupted.
module sdr_burst_hold #(
  parameter int BL = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o
);
  localparam int HW = (BL > 1) ? $clog2(BL) : 1;
  localparam logic [HW-1:0] LD = HW'(BL - 1);

  logic [HW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt_q <= '0;
    else if (start_i)        cnt_q <= LD;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/sdr_cmd_judge.sv
// Combinational legality decision for the presented command.
module sdr_cmd_judge
  import sdr_guard_pkg::*;
#(
  parameter int NB        = 4,
  parameter int BANK_W    = 2,
  parameter int FULL_PAGE = 0
) (
  input  logic [2:0]        code_i,
  input  logic [BANK_W-1:0] bank_i,
  input  logic              a10_i,
  input  logic [NB-1:0]     open_i,
  input  logic [NB-1:0]     pend_i,
  input  logic [NB-1:0]     rp_done_i,
  input  logic              busy_i,
  output logic              ok_o
);
  logic ap_banned;
  assign ap_banned = a10_i && (FULL_PAGE != 0);

  always_comb begin
    ok_o = 1'b0;
    case (cmd_e'(code_i))
      CMD_NOP: ok_o = 1'b1;
      CMD_ACT: ok_o = !open_i[bank_i] && rp_done_i[bank_i];
      CMD_RD,
      CMD_WR:  ok_o = !busy_i && open_i[bank_i] && !pend_i[bank_i] && !ap_banned;
      CMD_PRE: ok_o = !busy_i && (a10_i ? (pend_i == '0) : !pend_i[bank_i]);
      default: ok_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/sdr_bank_guard.sv
module sdr_bank_guard
  import sdr_guard_pkg::*;
#(
  parameter int BANK_W    = 2,
  parameter int BL        = 4,
  parameter int CL        = 2,
  parameter int TRP       = 2,
  parameter int TRAS      = 6,
  parameter int TWR       = 2,
  parameter int FULL_PAGE = 0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cmd_valid,
  input  logic [2:0]             cmd_code,
  input  logic [BANK_W-1:0]      cmd_bank,
  input  logic                   cmd_a10,
  output logic                   cmd_ready,
  output logic [(1<<BANK_W)-1:0] bank_open
);
  localparam int NB        = 1 << BANK_W;
  localparam int RD_LEAD   = CL - 1;                     // start before last read beat
  localparam int RD_AP_DLY = (CL + BL - 1) - RD_LEAD;    // from command to start
  localparam int WR_AP_DLY = (BL - 1) + TWR;             // last write beat plus tWR
  localparam int MAXV      = BL + CL + TWR + TRP + TRAS;
  localparam int CW        = $clog2(MAXV + 1);
  localparam logic [CW-1:0] RD_DLY_V = CW'(RD_AP_DLY);
  localparam logic [CW-1:0] WR_DLY_V = CW'(WR_AP_DLY);

  logic [NB-1:0] open_w, pend_w, rp_done_w;
  logic          busy_w, accept, is_rw, ap_go;

  assign accept = cmd_valid && cmd_ready;
  assign is_rw  = (cmd_code == CMD_RD) || (cmd_code == CMD_WR);
  assign ap_go  = accept && is_rw && cmd_a10;

  sdr_cmd_judge #(.NB(NB), .BANK_W(BANK_W), .FULL_PAGE(FULL_PAGE)) judge_i (
    .code_i(cmd_code), .bank_i(cmd_bank), .a10_i(cmd_a10),
    .open_i(open_w), .pend_i(pend_w), .rp_done_i(rp_done_w),
    .busy_i(busy_w), .ok_o(cmd_ready)
  );

  sdr_burst_hold #(.BL(BL)) hold_i (
    .clk(clk), .rst_n(rst_n), .start_i(ap_go), .busy_o(busy_w)
  );

  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic hit;
    assign hit = (cmd_bank == BANK_W'(b));
    sdr_bank_timer #(.CW(CW), .TRP(TRP), .TRAS(TRAS)) timer_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .act_i     (accept && (cmd_code == CMD_ACT) && hit),
      .pre_i     (accept && (cmd_code == CMD_PRE) && (cmd_a10 || hit)),
      .ap_i      (ap_go && hit),
      .ap_delay_i((cmd_code == CMD_WR) ? WR_DLY_V : RD_DLY_V),
      .open_o    (open_w[b]),
      .pend_o    (pend_w[b]),
      .rp_done_o (rp_done_w[b])
    );
  end

  assign bank_open = open_w;
endmodule

// File: rtl/sdr_bank_guard_chk.sv
module sdr_bank_guard_chk #(
  parameter int BANK_W    = 2,
  parameter int BL        = 4,
  parameter int FULL_PAGE = 0
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   cmd_valid,
  input logic [2:0]             cmd_code,
  input logic [BANK_W-1:0]      cmd_bank,
  input logic                   cmd_a10,
  input logic                   cmd_ready,
  input logic [(1<<BANK_W)-1:0] bank_open
);
  logic acc, rw, ap_acc;
  assign acc    = cmd_valid && cmd_ready;
  assign rw     = (cmd_code == 3'd2) || (cmd_code == 3'd3);
  assign ap_acc = acc && rw && cmd_a10;

  p_nop_ready_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_code == 3'd0) |-> cmd_ready);
  p_bad_code_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_code > 3'd4) |-> !cmd_ready);
  p_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> ((bank_open & ~$past(bank_open)) == '0));
  p_act_closed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd_code == 3'd1) && cmd_ready) |-> !bank_open[cmd_bank]);
  p_act_opens_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (cmd_code == 3'd1)) |=> bank_open[$past(cmd_bank)]);
  p_rw_open_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (rw && cmd_ready) |-> bank_open[cmd_bank]);
  p_lock_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((BL > 1) && ap_acc) |=> !(cmd_ready && (rw || cmd_code == 3'd4)));
  p_fullpage_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((FULL_PAGE != 0) && rw && cmd_a10) |-> !cmd_ready);
  p_pre_all_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && (cmd_code == 3'd4) && cmd_a10) |=> (bank_open == '0));

  always @(posedge clk)
    if (!rst_n) p_reset_r12: assert (bank_open == '0);
endmodule

bind sdr_bank_guard sdr_bank_guard_chk #(
  .BANK_W(BANK_W), .BL(BL), .FULL_PAGE(FULL_PAGE)
) chk_i (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
  .cmd_bank(cmd_bank), .cmd_a10(cmd_a10), .cmd_ready(cmd_ready),
  .bank_open(bank_open)
);

// File: tb/sdr_bank_guard_tb_top.sv
`timescale 1ns/1ps
module sdr_bank_guard_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b1;
  logic       cmd_valid = 1'b0, cmd_a10 = 1'b0;
  logic [2:0] cmd_code = 3'd0;
  logic [1:0] cmd_bank = 2'd0;
  logic       cmd_ready;
  logic [3:0] bank_open;
  logic       fp_valid = 1'b0, fp_a10 = 1'b0;
  logic [2:0] fp_code = 3'd0;
  logic [1:0] fp_bank = 2'd0;
  logic       fp_ready;
  logic [3:0] fp_open;
  int         checks = 0, fails = 0;
  bit         done = 1'b0;

  always #5 clk = ~clk;

  sdr_bank_guard #(.BANK_W(2), .BL(4), .CL(2), .TRP(2), .TRAS(6), .TWR(2), .FULL_PAGE(0)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .cmd_bank(cmd_bank), .cmd_a10(cmd_a10), .cmd_ready(cmd_ready), .bank_open(bank_open));

  sdr_bank_guard #(.BANK_W(2), .BL(4), .CL(2), .TRP(2), .TRAS(6), .TWR(2), .FULL_PAGE(1)) dut_fp (
    .clk(clk), .rst_n(rst_n), .cmd_valid(fp_valid), .cmd_code(fp_code),
    .cmd_bank(fp_bank), .cmd_a10(fp_a10), .cmd_ready(fp_ready), .bank_open(fp_open));

  // {req[15:12], valid[11], code[10:8], bank[7:6], a10[5], ready[4], open[3:0]}
  localparam int NV = 34;
  localparam logic [15:0] VEC [NV] = '{
    {4'd12, 1'b1, 3'd0, 2'd0, 1'b0, 1'b1, 4'b0000}, // R12 state after reset
    {4'd4,  1'b1, 3'd2, 2'd0, 1'b0, 1'b0, 4'b0000}, // R4 read to closed bank
    {4'd3,  1'b1, 3'd1, 2'd0, 1'b0, 1'b1, 4'b0001}, // R3 activate b0
    {4'd3,  1'b1, 3'd1, 2'd0, 1'b0, 1'b0, 4'b0001}, // R3 activate open bank
    {4'd5,  1'b1, 3'd2, 2'd0, 1'b1, 1'b1, 4'b0001}, // R5 read with auto-precharge
    {4'd7,  1'b1, 3'd1, 2'd1, 1'b0, 1'b1, 4'b0011}, // R7 activate allowed in lock
    {4'd7,  1'b1, 3'd3, 2'd1, 1'b0, 1'b0, 4'b0011}, // R7 write blocked
    {4'd7,  1'b1, 3'd4, 2'd1, 1'b0, 1'b0, 4'b0011}, // R7 precharge blocked
    {4'd5,  1'b1, 3'd2, 2'd0, 1'b0, 1'b0, 4'b0010}, // R5 closing bank; closes here
    {4'd5,  1'b1, 3'd1, 2'd0, 1'b0, 1'b0, 4'b0010}, // R5 tRP not yet met
    {4'd5,  1'b1, 3'd1, 2'd0, 1'b0, 1'b1, 4'b0011}, // R5 reactivate
    {4'd6,  1'b1, 3'd3, 2'd1, 1'b1, 1'b1, 4'b0011}, // R6 write with auto-precharge
    {4'd7,  1'b1, 3'd3, 2'd0, 1'b0, 1'b0, 4'b0011}, // R7 write blocked
    {4'd1,  1'b1, 3'd0, 2'd0, 1'b0, 1'b1, 4'b0011}, // R1 no-op
    {4'd7,  1'b1, 3'd2, 2'd0, 1'b0, 1'b0, 4'b0011}, // R7 read blocked, last cycle
    {4'd9,  1'b1, 3'd4, 2'd0, 1'b1, 1'b0, 4'b0011}, // R9 all-bank blocked by pending
    {4'd9,  1'b1, 3'd4, 2'd0, 1'b0, 1'b1, 4'b0000}, // R9 single close; b1 auto closes
    {4'd6,  1'b1, 3'd1, 2'd1, 1'b0, 1'b0, 4'b0000}, // R6 tDAL not met
    {4'd6,  1'b1, 3'd1, 2'd1, 1'b0, 1'b1, 4'b0010}, // R6 tDAL met
    {4'd11, 1'b1, 3'd2, 2'd1, 1'b1, 1'b1, 4'b0010}, // R11 early auto read
    {4'd7,  1'b1, 3'd4, 2'd0, 1'b0, 1'b0, 4'b0010}, // R7 precharge blocked
    {4'd1,  1'b1, 3'd0, 2'd0, 1'b0, 1'b1, 4'b0010}, // R1
    {4'd1,  1'b1, 3'd0, 2'd0, 1'b0, 1'b1, 4'b0010}, // R1
    {4'd11, 1'b1, 3'd0, 2'd0, 1'b0, 1'b1, 4'b0010}, // R11 start held for tRAS
    {4'd11, 1'b1, 3'd0, 2'd0, 1'b0, 1'b1, 4'b0000}, // R11 closes now
    {4'd3,  1'b1, 3'd1, 2'd1, 1'b0, 1'b0, 4'b0000}, // R3 tRP
    {4'd3,  1'b1, 3'd1, 2'd1, 1'b0, 1'b1, 4'b0010}, // R3
    {4'd10, 1'b1, 3'd4, 2'd2, 1'b0, 1'b1, 4'b0010}, // R10 precharge closed bank
    {4'd10, 1'b1, 3'd1, 2'd2, 1'b0, 1'b1, 4'b0110}, // R10 no recovery started
    {4'd9,  1'b1, 3'd4, 2'd0, 1'b1, 1'b1, 4'b0000}, // R9 all banks
    {4'd3,  1'b1, 3'd1, 2'd1, 1'b0, 1'b0, 4'b0000}, // R3 tRP after all-bank
    {4'd1,  1'b1, 3'd7, 2'd0, 1'b0, 1'b0, 4'b0000}, // R1 invalid code
    {4'd2,  1'b0, 3'd1, 2'd3, 1'b0, 1'b1, 4'b0000}, // R2 not valid, no effect
    {4'd2,  1'b1, 3'd1, 2'd3, 1'b0, 1'b1, 4'b1000}  // R2 accepted
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  initial begin
    #1 rst_n = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    for (int n = 0; n < NV; n++) begin
      logic [15:0] v;
      string tag;
      v = VEC[n];
      tag = $sformatf("R%0d vec%0d", v[15:12], n);
      @(negedge clk);
      cmd_valid = v[11]; cmd_code = v[10:8]; cmd_bank = v[7:6]; cmd_a10 = v[5];
      #1 chk(cmd_ready == v[4], {tag, " ready"}, cmd_ready, v[4]);
      @(posedge clk); #1;
      chk(bank_open == v[3:0], {tag, " open"}, bank_open, v[3:0]);
    end
    // R8: full-page instance refuses auto-precharge only
    @(negedge clk);
    cmd_valid = 1'b0;
    fp_valid = 1'b1; fp_code = 3'd1; fp_bank = 2'd0; fp_a10 = 1'b0;
    #1 chk(fp_ready == 1'b1, "R8 activate", fp_ready, 1);
    @(negedge clk);
    fp_code = 3'd2; fp_a10 = 1'b1;
    #1 chk(fp_ready == 1'b0, "R8 auto read refused", fp_ready, 0);
    fp_code = 3'd3;
    #1 chk(fp_ready == 1'b0, "R8 auto write refused", fp_ready, 0);
    fp_a10 = 1'b0;
    #1 chk(fp_ready == 1'b1, "R8 plain write ready", fp_ready, 1);
    fp_valid = 1'b0;
    // R12: reset mid-run clears banks and timers
    @(negedge clk);
    cmd_valid = 1'b1; cmd_code = 3'd4; cmd_bank = 2'd3; cmd_a10 = 1'b0;
    @(negedge clk);
    cmd_valid = 1'b0;
    rst_n = 1'b0;
    #1 chk(bank_open == 4'b0000, "R12 reset closes", bank_open, 0);
    @(negedge clk) rst_n = 1'b1;
    cmd_code = 3'd1; cmd_bank = 2'd3;
    #1 chk(cmd_ready == 1'b1, "R12 activate ready after reset", cmd_ready, 1);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule